// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block sits between a set of device interrupt lines and the processor interrupt fabric. Each input pin has a 64-bit redirection entry. The entry tells the block how to recognise the pin: edge or level sensitive, active high or active low, masked or open. It also holds the message to send when the pin fires: vector, delivery mode, destination mode and destination. When an unmasked pin becomes active, the block latches a send-pending flag for that pin. A dispatcher then hands one message at a time to the downstream fabric over a valid/ready handshake. A level-sensitive pin then stays blocked by a remote-acknowledge flag until an end-of-interrupt message arrives carrying the same vector.

Software reaches all state through a single 32-bit port with two locations. Location 0 holds a register index. Location 1 is a window onto the 32-bit register that the index selects. The registers behind the window are:
- an identification register;
- a read-only version register that also reports the table size;
- an arbitration register;
- the redirection table, two consecutive indices per pin.

The dispatcher is a two-state machine. In ST_IDLE it waits for a pending request. The transition IDLE_TO_SEND is taken when at least one unmasked pin has its pending flag set. On that transition the lowest-numbered such pin is chosen and its message fields are captured. In ST_SEND the dispatcher drives the message with valid held high. The transition SEND_TO_IDLE is taken on the cycle ready is seen; on that cycle the pin is granted, which clears its pending flag and, for a level entry, sets its remote-acknowledge flag.

Top module: `irq_redir_ctrl`

## Requirements
- R1: A write with `bus_win`=0 loads the 8-bit index register from `bus_wdata[7:0]`. With `bus_win`=0, `bus_rdata` shows the index, zero-extended. With `bus_win`=1, reads and writes go to the register the index selects.
- R2: Index 0x00 is the identification register. It resets to 0. Bits 27:24 are writable and all other bits read as zero.
- R3: Index 0x01 is the version register and reads `{8'h00, NUM_PINS-1, 8'h00, VERSION}`. With the defaults this is 0x00170011. Writes to it have no effect.
- R4: Index 0x02 is the arbitration register. It resets to 0. Bits 27:24 are writable and all other bits read as zero.
- R5: Pin n has its low word at index 0x10+2n and its high word at index 0x11+2n. The low word fields are:
  - bits 7:0: vector
  - bits 10:8: delivery mode
  - bit 11: destination mode (0 physical, 1 logical)
  - bit 12: send pending, read-only
  - bit 13: polarity (0 active high, 1 active low)
  - bit 14: remote acknowledge, read-only
  - bit 15: trigger (0 edge, 1 level)
  - bit 16: mask (1 = disabled)

  The high word holds the destination in bits 31:24. All other bits of both words, and every index that selects no register, read as zero.
- R6: After reset every low word reads 0x00010000 and every high word reads 0x00000000.
- R7: On an edge entry, an inactive-to-active transition of an unmasked pin sets the send-pending bit. It also produces one message carrying the entry's vector, delivery mode, destination mode and destination. The send-pending bit clears when the handshake completes. A pin that is held active sends nothing more.
- R8: With polarity 1, a pin is active when low. Its falling edge triggers a message and its rising edge triggers none.
- R9: A masked pin produces no message and does not set send pending. An edge that arrives while the pin is masked is lost: unmasking the pin while it is still active sends nothing.
- R10: An active, unmasked level entry sends one message and sets remote acknowledge. It sends nothing more until an end-of-interrupt with the same vector clears remote acknowledge. An end-of-interrupt with a different vector has no effect. If the pin is still active once remote acknowledge clears, a new message follows.
- R11: When several pins are pending at once, messages go out in ascending pin order.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and all message fields hold. After a completed handshake, `msg_valid` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = index register, 1 = data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the location `bus_win` selects |
| irq_pin | input | NUM_PINS | Interrupt input pins |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dstmode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
The hardest state to reach from the ports is a level pin that stays active across its end-of-interrupt. Reaching it requires a delivered message, a blocked re-send, a non-matching end-of-interrupt that must change nothing, and then a matching one that must cause exactly one new message while the pin is still held. The bench walks a level pin through that whole order and reads the remote-acknowledge bit back through the window between the steps. Ordering is forced by holding ready low while a chosen subset of pins rises in the same cycle. The bench does this for every non-empty subset of a four-pin configuration, so pending flags collide in every combination before the dispatcher drains them.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Software-configurable part of one redirection entry
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       pol;
        logic       dstmode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } entry_cfg_t;

    // Fields carried by one outgoing message
    typedef struct packed {
        logic [7:0] dest;
        logic       dstmode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } msg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } disp_state_t;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam int unsigned TBL_BASE = 16;

    localparam entry_cfg_t ENT_RESET = '{
        dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
        dstmode: 1'b0, dmode: 3'h0, vector: 8'h00
    };

endpackage

// File: rtl/irq_redir_pin.sv
module irq_redir_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       pol_i,
    input  logic       trig_i,
    input  logic       mask_i,
    input  logic [7:0] vector_i,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    input  logic       grant_i,
    output logic       status_o,
    output logic       irr_o,
    output logic       req_o
);

    logic act;
    logic act_q;
    logic sts_q;
    logic irr_q;
    logic edge_hit;
    logic lvl_hit;
    logic eoi_hit;

    assign act      = pin_i ^ pol_i;
    assign edge_hit = ~trig_i & act & ~act_q & ~mask_i;
    assign lvl_hit  = trig_i & act & ~mask_i & ~irr_q & ~sts_q;
    assign eoi_hit  = eoi_valid & trig_i & irr_q & (eoi_vector == vector_i);

    // Last seen activity level, tracked even while masked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act;
        end
    end

    // Send pending: a new trigger wins over a grant in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (edge_hit || lvl_hit) begin
            sts_q <= 1'b1;
        end else if (grant_i) begin
            sts_q <= 1'b0;
        end
    end

    // Remote acknowledge for level entries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q <= 1'b0;
        end else if (grant_i && trig_i) begin
            irr_q <= 1'b1;
        end else if (eoi_hit) begin
            irr_q <= 1'b0;
        end
    end

    assign status_o = sts_q;
    assign irr_o    = irr_q;
    assign req_o    = sts_q & ~mask_i;

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic                       bus_win,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_PINS-1:0]        sts_i,
    input  logic [NUM_PINS-1:0]        irr_i,
    output entry_cfg_t [NUM_PINS-1:0]  cfg_o
);

    localparam logic [7:0] MAX_ENT = 8'(NUM_PINS - 1);

    logic [7:0]  idx_q;
    logic [3:0]  id_q;
    logic [3:0]  arb_q;
    logic        wr_idx;
    logic        wr_win;
    logic [31:0] win_val;
    logic        unused_wbits;

    assign wr_idx = bus_valid & bus_write & ~bus_win;
    assign wr_win = bus_valid & bus_write & bus_win;
    assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (wr_idx) begin
            idx_q <= bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= 4'h0;
            arb_q <= 4'h0;
        end else if (wr_win) begin
            if (idx_q == IDX_ID) begin
                id_q <= bus_wdata[27:24];
            end
            if (idx_q == IDX_ARB) begin
                arb_q <= bus_wdata[27:24];
            end
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        localparam logic [7:0] LO_IDX = 8'(TBL_BASE + 2 * g);
        localparam logic [7:0] HI_IDX = 8'(TBL_BASE + 2 * g + 1);
        entry_cfg_t ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= ENT_RESET;
            end else if (wr_win && idx_q == LO_IDX) begin
                ent_q.vector  <= bus_wdata[7:0];
                ent_q.dmode   <= bus_wdata[10:8];
                ent_q.dstmode <= bus_wdata[11];
                ent_q.pol     <= bus_wdata[13];
                ent_q.trig    <= bus_wdata[15];
                ent_q.mask    <= bus_wdata[16];
            end else if (wr_win && idx_q == HI_IDX) begin
                ent_q.dest <= bus_wdata[31:24];
            end
        end

        assign cfg_o[g] = ent_q;
    end

    always_comb begin
        win_val = 32'h0;
        if (idx_q == IDX_ID) begin
            win_val = {4'h0, id_q, 24'h0};
        end else if (idx_q == IDX_VER) begin
            win_val = {8'h00, MAX_ENT, 8'h00, VERSION};
        end else if (idx_q == IDX_ARB) begin
            win_val = {4'h0, arb_q, 24'h0};
        end
        for (int i = 0; i < NUM_PINS; i++) begin
            if (idx_q == 8'(TBL_BASE + 2 * i)) begin
                win_val = {15'h0, cfg_o[i].mask, cfg_o[i].trig, irr_i[i],
                           cfg_o[i].pol, sts_i[i], cfg_o[i].dstmode,
                           cfg_o[i].dmode, cfg_o[i].vector};
            end
            if (idx_q == 8'(TBL_BASE + 2 * i + 1)) begin
                win_val = {cfg_o[i].dest, 24'h0};
            end
        end
    end

    assign bus_rdata = bus_win ? win_val : {24'h0, idx_q};

endmodule

// File: rtl/irq_redir_disp.sv
module irq_redir_disp
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   req_i,
    input  msg_t [NUM_PINS-1:0]   msg_i,
    input  logic                  msg_ready,
    output logic                  msg_valid,
    output logic [7:0]            msg_vector,
    output logic [2:0]            msg_dmode,
    output logic                  msg_dstmode,
    output logic [7:0]            msg_dest,
    output logic [NUM_PINS-1:0]   grant_o
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    disp_state_t      st_q;
    disp_state_t      st_d;
    logic [PIN_W-1:0] win_idx;
    logic [PIN_W-1:0] sel_q;
    logic             any_req;
    msg_t             snap_q;

    // Lowest pending pin wins
    always_comb begin
        win_idx = '0;
        any_req = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                win_idx = PIN_W'(i);
                any_req = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (any_req)   st_d = ST_SEND;
            ST_SEND: if (msg_ready) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            snap_q <= '0;
        end else if (st_q == ST_IDLE && any_req) begin
            sel_q  <= win_idx;
            snap_q <= msg_i[win_idx];
        end
    end

    always_comb begin
        msg_valid = 1'b0;
        grant_o   = '0;
        unique case (st_q)
            ST_IDLE: msg_valid = 1'b0;
            ST_SEND: begin
                msg_valid = 1'b1;
                if (msg_ready) begin
                    grant_o[sel_q] = 1'b1;
                end
            end
            default: msg_valid = 1'b0;
        endcase
    end

    assign msg_vector  = snap_q.vector;
    assign msg_dmode   = snap_q.dmode;
    assign msg_dstmode = snap_q.dstmode;
    assign msg_dest    = snap_q.dest;

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic                bus_win,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pin,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_dmode,
    output logic                msg_dstmode,
    output logic [7:0]          msg_dest,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);

    entry_cfg_t [NUM_PINS-1:0] cfg_w;
    msg_t       [NUM_PINS-1:0] msg_w;
    logic       [NUM_PINS-1:0] sts_w;
    logic       [NUM_PINS-1:0] irr_w;
    logic       [NUM_PINS-1:0] req_w;
    logic       [NUM_PINS-1:0] grant_w;

    irq_redir_regs #(
        .NUM_PINS (NUM_PINS),
        .VERSION  (VERSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_win   (bus_win),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sts_i     (sts_w),
        .irr_i     (irr_w),
        .cfg_o     (cfg_w)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign msg_w[g] = '{
            dest:    cfg_w[g].dest,
            dstmode: cfg_w[g].dstmode,
            dmode:   cfg_w[g].dmode,
            vector:  cfg_w[g].vector
        };

        irq_redir_pin u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (irq_pin[g]),
            .pol_i      (cfg_w[g].pol),
            .trig_i     (cfg_w[g].trig),
            .mask_i     (cfg_w[g].mask),
            .vector_i   (cfg_w[g].vector),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant_i    (grant_w[g]),
            .status_o   (sts_w[g]),
            .irr_o      (irr_w[g]),
            .req_o      (req_w[g])
        );
    end

    irq_redir_disp #(
        .NUM_PINS (NUM_PINS)
    ) u_disp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_w),
        .msg_i       (msg_w),
        .msg_ready   (msg_ready),
        .msg_valid   (msg_valid),
        .msg_vector  (msg_vector),
        .msg_dmode   (msg_dmode),
        .msg_dstmode (msg_dstmode),
        .msg_dest    (msg_dest),
        .grant_o     (grant_w)
    );

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      msg_valid,
    input logic                      msg_ready,
    input logic [7:0]                msg_vector,
    input logic [2:0]                msg_dmode,
    input logic                      msg_dstmode,
    input logic [7:0]                msg_dest,
    input logic                      eoi_valid,
    input logic [7:0]                eoi_vector,
    input logic [NUM_PINS-1:0]       grant,
    input logic [NUM_PINS-1:0]       irr,
    input logic [NUM_PINS-1:0]       sts,
    input entry_cfg_t [NUM_PINS-1:0] cfg
);

    logic unused_cfg;
    assign unused_cfg = ^cfg;

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
            $stable(msg_dmode) && $stable(msg_dstmode) && $stable(msg_dest)));

    p_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        p_level_irr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && cfg[i].trig) |=> irr[i]);

        p_eoi_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (irr[i] && !(eoi_valid && eoi_vector == cfg[i].vector)) |=> irr[i]);

        p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts[i]) |-> !$past(cfg[i].mask));
    end

endmodule

bind irq_redir_ctrl irq_redir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_vector  (msg_vector),
    .msg_dmode   (msg_dmode),
    .msg_dstmode (msg_dstmode),
    .msg_dest    (msg_dest),
    .eoi_valid   (eoi_valid),
    .eoi_vector  (eoi_vector),
    .grant       (grant_w),
    .irr         (irr_w),
    .sts         (sts_w),
    .cfg         (cfg_w)
);

// File: tb/irq_redir_ctrl_bench.sv
module irq_redir_ctrl_bench;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_win = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] irq_pin = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dmode;
    logic        msg_dstmode;
    logic [7:0]  msg_dest;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = 8'h0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int log_n = 0;
    logic [7:0] log_vec [0:63];

    always #4 clk = ~clk;

    irq_redir_ctrl #(.NUM_PINS(NP)) u_irq_redir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_win(bus_win),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode),
        .msg_dstmode(msg_dstmode), .msg_dest(msg_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    // Record every completed handshake
    always @(negedge clk) begin
        #2;
        if (rst_n && msg_valid && msg_ready) begin
            log_vec[log_n[5:0]] = msg_vector;
            log_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog R1..: actual=%0d cycles expected=finish", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic win, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_win = win; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
        bus_wr(1'b0, {24'h0, idx});
        bus_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
        bus_wr(1'b0, {24'h0, idx});
        bus_win = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R6 reset sweep of all table words, R2/R3/R4 reset values
        for (int p = 0; p < NP; p++) begin
            reg_rd(8'(16 + 2 * p), rd); chk("R6", "reset low word", rd, 32'h0001_0000);
            reg_rd(8'(17 + 2 * p), rd); chk("R6", "reset high word", rd, 32'h0);
        end
        chk("R12", "no message after reset", {31'h0, msg_valid}, 32'h0);
        reg_rd(8'h00, rd); chk("R2", "id reset", rd, 32'h0);
        reg_rd(8'h01, rd); chk("R3", "version", rd, {8'h0, 8'(NP - 1), 8'h0, 8'h11});
        reg_rd(8'h02, rd); chk("R4", "arb reset", rd, 32'h0);

        // R1 index readback
        bus_wr(1'b0, 32'hFFFF_FF13);
        bus_win = 1'b0;
        #1 chk("R1", "index readback", bus_rdata, 32'h13);

        // R2, R4, R3 write behaviour
        reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, rd); chk("R2", "id write", rd, 32'h0F00_0000);
        reg_wr(8'h02, 32'hFFFF_FFFF); reg_rd(8'h02, rd); chk("R4", "arb write", rd, 32'h0F00_0000);
        reg_wr(8'h01, 32'hFFFF_FFFF); reg_rd(8'h01, rd); chk("R3", "version write ignored", rd, {8'h0, 8'(NP - 1), 8'h0, 8'h11});

        // R5 field sweep over every entry
        for (int p = 0; p < NP; p++) begin
            reg_wr(8'(16 + 2 * p), 32'hFFFF_FFFF);
            reg_rd(8'(16 + 2 * p), rd); chk("R5", "low word writable bits", rd, 32'h0001_AFFF);
            reg_wr(8'(17 + 2 * p), 32'hFFFF_FFFF);
            reg_rd(8'(17 + 2 * p), rd); chk("R5", "high word dest", rd, 32'hFF00_0000);
            reg_wr(8'(16 + 2 * p), 32'h0001_0000);
            reg_wr(8'(17 + 2 * p), 32'h0);
        end
        reg_rd(8'(16 + 2 * NP), rd); chk("R5", "index past table", rd, 32'h0);
        reg_rd(8'h05, rd); chk("R5", "unused index", rd, 32'h0);
        chk("R9", "masked entries sent nothing", log_n, 0);

        // R7 edge delivery on every pin, with R12 hold
        for (int p = 0; p < NP; p++) begin
            logic [31:0] lo;
            lo = 32'(8'h40 + p) | (32'(p & 7) << 8) | (32'(p & 1) << 11);
            msg_ready = 1'b0;
            reg_wr(8'(16 + 2 * p), lo);
            reg_wr(8'(17 + 2 * p), 32'(8'h80 | p) << 24);
            @(negedge clk); irq_pin[p] = 1'b1;
            idle(4);
            chk("R7", "valid after edge", {31'h0, msg_valid}, 32'h1);
            chk("R7", "vector", {24'h0, msg_vector}, 32'(8'h40 + p));
            chk("R7", "dmode", {29'h0, msg_dmode}, 32'(p & 7));
            chk("R7", "dstmode", {31'h0, msg_dstmode}, 32'(p & 1));
            chk("R7", "dest", {24'h0, msg_dest}, 32'(8'h80 | p));
            reg_rd(8'(16 + 2 * p), rd); chk("R7", "pending bit set", rd, lo | 32'h1000);
            idle(3);
            chk("R12", "valid held", {31'h0, msg_valid}, 32'h1);
            chk("R12", "vector held", {24'h0, msg_vector}, 32'(8'h40 + p));
            base = log_n;
            msg_ready = 1'b1;
            idle(1);
            msg_ready = 1'b0;
            idle(2);
            chk("R12", "valid dropped", {31'h0, msg_valid}, 32'h0);
            chk("R7", "one message", log_n - base, 1);
            reg_rd(8'(16 + 2 * p), rd); chk("R7", "pending bit cleared", rd, lo);
            msg_ready = 1'b1;
            idle(10);
            chk("R7", "held pin silent", log_n - base, 1);
            irq_pin[p] = 1'b0;
            reg_wr(8'(16 + 2 * p), 32'h0001_0000);
        end

        // R8 active-low edge on pin 1
        msg_ready = 1'b1;
        @(negedge clk); irq_pin[1] = 1'b1;
        idle(2);
        base = log_n;
        reg_wr(8'h12, 32'h0000_2041);
        idle(4);
        chk("R8", "inactive high pin silent", log_n - base, 0);
        irq_pin[1] = 1'b0; idle(6);
        chk("R8", "falling edge sends", log_n - base, 1);
        chk("R8", "vector", {24'h0, log_vec[base[5:0]]}, 32'h41);
        irq_pin[1] = 1'b1; idle(6);
        chk("R8", "rising edge silent", log_n - base, 1);
        reg_wr(8'h12, 32'h0001_0000);
        irq_pin[1] = 1'b0; idle(2);

        // R9 mask on pin 3
        base = log_n;
        reg_wr(8'h16, 32'h0001_0043);
        @(negedge clk); irq_pin[3] = 1'b1; idle(6);
        chk("R9", "masked edge silent", log_n - base, 0);
        reg_rd(8'h16, rd); chk("R9", "masked pending clear", rd, 32'h0001_0043);
        reg_wr(8'h16, 32'h0000_0043); idle(6);
        chk("R9", "edge lost while masked", log_n - base, 0);
        irq_pin[3] = 1'b0; idle(2);
        irq_pin[3] = 1'b1; idle(6);
        chk("R9", "fresh edge after unmask", log_n - base, 1);
        chk("R9", "vector", {24'h0, log_vec[base[5:0]]}, 32'h43);
        irq_pin[3] = 1'b0;
        reg_wr(8'h16, 32'h0001_0000);

        // R10 level entry on pin 2
        base = log_n;
        reg_wr(8'h14, 32'h0000_8062);
        @(negedge clk); irq_pin[2] = 1'b1; idle(8);
        chk("R10", "one level message", log_n - base, 1);
        reg_rd(8'h14, rd); chk("R10", "remote ack set", rd, 32'h0000_C062);
        eoi(8'h63); idle(6);
        chk("R10", "wrong eoi no resend", log_n - base, 1);
        reg_rd(8'h14, rd); chk("R10", "remote ack kept", rd, 32'h0000_C062);
        eoi(8'h62); idle(6);
        chk("R10", "resend after eoi", log_n - base, 2);
        chk("R10", "resend vector", {24'h0, log_vec[6'(base + 1)]}, 32'h62);
        irq_pin[2] = 1'b0;
        eoi(8'h62); idle(6);
        chk("R10", "inactive after eoi silent", log_n - base, 2);
        reg_rd(8'h14, rd); chk("R10", "remote ack cleared", rd, 32'h0000_8062);
        reg_wr(8'h14, 32'h0001_0000);

        // R11 ordering over every non-empty pin subset
        for (int p = 0; p < NP; p++) reg_wr(8'(16 + 2 * p), 32'(8'h50 + p));
        for (int s = 1; s < (1 << NP); s++) begin
            int k;
            msg_ready = 1'b0;
            @(negedge clk); irq_pin = NP'(s);
            idle(3);
            base = log_n;
            msg_ready = 1'b1;
            idle(14);
            msg_ready = 1'b0;
            chk("R11", "message count", log_n - base, $countones(NP'(s)));
            k = 0;
            for (int p = 0; p < NP; p++) begin
                if (s[p]) begin
                    chk("R11", "ascending order", {24'h0, log_vec[6'(base + k)]}, 32'(8'h50 + p));
                    k++;
                end
            end
            irq_pin = '0;
            idle(2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule